// File: doc/BRIEF.md
# Host Control Register Slave on a Two-Wire Serial Bus

This block is a serial two-wire bus slave (I2C, fast mode up to 400 kHz) that owns one 8-bit host control register for a card interface. The SCL and SDA lines are sampled with the system clock, which must run at least eight times the SCL rate. The block detects START and STOP conditions, compares the address byte with its own address, and acknowledges a match. On a write it takes in data bytes and acknowledges each one. On a read it returns the current register value. The slave does not stretch the clock. It drives SDA only by pulling it low, through an open-drain style output.

Three strap inputs choose one of eight bus addresses, so up to eight of these slaves can share one bus. The straps map to the addresses in a rotated order, not a linear one. Each register bit drives its own control output. The warm-reset request bit also has a hardware clear: card-side logic clears it when the card starts to answer or when the card is declared mute.

Top module: `hcr_i2c_slave`

## Requirements
- R1: After reset, all eight control outputs are 0 (register value 0x00) and `sda_pull_low` is 0.
- R2: The 7-bit own address is 0x20 OR ((addr_sel + 5) mod 8). The straps 0..7 give 0x25, 0x26, 0x27, 0x20, 0x21, 0x22, 0x23, 0x24, which are address bytes 0x4A..0x48 with R/W=0. The slave acknowledges (pulls SDA low during the ninth clock) only an address byte whose upper seven bits equal its own address.
- R3: After an address mismatch the slave stays idle with SDA released until the next START. It acknowledges no following byte and leaves the register unchanged.
- R4: A write is START, then the address with R/W (bit 0) = 0, then an ACK from the slave, then 8 data bits sent MSB first, then an ACK from the slave. The data byte then becomes the register value. The bit mapping is: bit0 `act_req`, bit1 `warm_req`, bit2 `vcc_3v_sel`, bit3 `card_clk_halt`, bit4 `card_clk_halt_high`, bits6:5 `card_clk_rate[1:0]`, bit7 `aux_io_en`.
- R5: After an address byte with R/W = 1 and its ACK, the slave shifts out the register value MSB first. A master ACK makes it send the value again. A master NACK makes it release SDA and go idle.
- R6: A high level on `card_answer` or `card_mute` clears bit1 on the next clock and leaves the other bits unchanged.
- R7: When a hardware clear and a register write arrive in the same cycle, bit1 ends at 0 and the other bits take the written value.
- R8: A repeated START restarts address reception, whatever the slave was doing.
- R9: Within one write transaction, every further data byte is acknowledged and overwrites the register.
- R10: A STOP releases SDA and ends the transaction. A data byte cut short by a STOP does not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 3 | Address strap inputs |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| sda_pull_low | output | 1 | 1 pulls SDA low (open-drain drive) |
| card_answer | input | 1 | Card has started answering; clears bit1 |
| card_mute | input | 1 | Card declared mute; clears bit1 |
| act_req | output | 1 | Bit0: activation (1) or deactivation (0) request |
| warm_req | output | 1 | Bit1: warm-reset request |
| vcc_3v_sel | output | 1 | Bit2: card supply 3 V when 1, 5 V when 0 |
| card_clk_halt | output | 1 | Bit3: stop the card clock |
| card_clk_halt_high | output | 1 | Bit4: stopped clock level high when 1 |
| card_clk_rate | output | 2 | Bits6:5: card clock rate select |
| aux_io_en | output | 1 | Bit7: connect card-side and host-side auxiliary I/O |

## Verification
The assertions assume that `card_answer` and `card_mute` are synchronous to `clk`. They also assume that SDA changes only while SCL is low, except in deliberate START and STOP conditions, and that SCL is slow enough for the synchronizer to see every edge. The stimulus keeps within these limits: it holds each SCL quarter period for ten system clocks and changes SDA only in the quarter after SCL falls. It drives the card inputs on falling clock edges. A START, a repeated START or a STOP is always produced with SCL high for a full quarter period on each side of the SDA change.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int HCR_DW        = 8;
  localparam int HCR_AW        = 7;
  localparam int HCR_SEL_W     = 3;
  localparam int HCR_WARM_BIT  = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } hcr_state_e;

  // Low strap-width bits of the address are the strap code rotated by ROT.
  function automatic logic [HCR_AW-1:0] hcr_rot_addr(
    input logic [HCR_SEL_W-1:0] sel,
    input logic [HCR_AW-1:0]    base,
    input logic [HCR_SEL_W-1:0] rot
  );
    logic [HCR_SEL_W-1:0] low;
    low = sel + rot;
    return base | {{(HCR_AW-HCR_SEL_W){1'b0}}, low};
  endfunction
endpackage

// File: rtl/hcr_line_sync.sv
module hcr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_pipe[STAGES-1];
    sda_s     = sda_pipe[STAGES-1];
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/hcr_addr_map.sv
module hcr_addr_map
  import hcr_pkg::*;
#(
  parameter logic [HCR_AW-1:0]    BASE = 7'h20,
  parameter logic [HCR_SEL_W-1:0] ROT  = 3'd5
) (
  input  logic [HCR_SEL_W-1:0] sel,
  output logic [HCR_AW-1:0]    addr
);
  localparam int N = 1 << HCR_SEL_W;

  logic [HCR_AW-1:0] lut [N];

  for (genvar g = 0; g < N; g++) begin : g_lut
    assign lut[g] = hcr_rot_addr(HCR_SEL_W'(g), BASE, ROT);
  end

  assign addr = lut[sel];
endmodule

// File: rtl/hcr_byte_fsm.sv
module hcr_byte_fsm
  import hcr_pkg::*;
#(
  parameter int DW = HCR_DW,
  parameter int AW = HCR_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [AW-1:0] own_addr,
  input  logic [DW-1:0] reg_val,
  output logic          sda_low,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          idle
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  hcr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [DW-1:0] tx_q, tx_d;
  logic          flag_q, flag_d;
  logic          rw_q, rw_d;
  logic          low_q, low_d;
  logic          stb_q, stb_d;
  logic          adv_en;

  assign adv_en = start_det | stop_det | scl_rise | scl_fall;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    flag_d  = flag_q;
    rw_d    = rw_q;
    low_d   = low_q;
    stb_d   = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      flag_d  = 1'b0;
      low_d   = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      flag_d  = 1'b0;
      low_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx_d = {rx_q[DW-2:0], sda_s};
            if (cnt_q == LAST) flag_d = 1'b1;
            else               cnt_d  = cnt_q + 1'b1;
          end else if (scl_fall && flag_q) begin
            flag_d = 1'b0;
            cnt_d  = '0;
            if (state_q == ST_WDATA) begin
              stb_d   = 1'b1;
              low_d   = 1'b1;
              state_d = ST_WDATA_ACK;
            end else if (rx_q[DW-1:1] == own_addr) begin
              low_d   = 1'b1;
              rw_d    = rx_q[0];
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d  = '0;
            flag_d = 1'b0;
            if (rw_q) begin
              tx_d    = reg_val;
              low_d   = ~reg_val[DW-1];
              state_d = ST_RDATA;
            end else begin
              low_d   = 1'b0;
              state_d = ST_WDATA;
            end
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            low_d   = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == LAST) begin
              low_d   = 1'b0;
              flag_d  = 1'b0;
              state_d = ST_RDATA_ACK;
            end else begin
              tx_d  = {tx_q[DW-2:0], 1'b0};
              low_d = ~tx_q[DW-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) begin
            flag_d = ~sda_s;
          end else if (scl_fall) begin
            if (flag_q) begin
              tx_d    = reg_val;
              low_d   = ~reg_val[DW-1];
              cnt_d   = '0;
              flag_d  = 1'b0;
              state_d = ST_RDATA;
            end else begin
              low_d   = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      flag_q  <= 1'b0;
      rw_q    <= 1'b0;
      low_q   <= 1'b0;
    end else if (adv_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      flag_q  <= flag_d;
      rw_q    <= rw_d;
      low_q   <= low_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign sda_low = low_q;
  assign wr_stb  = stb_q;
  assign wr_data = rx_q;
  assign idle    = (state_q == ST_IDLE);
endmodule

// File: rtl/hcr_ctrl_reg.sv
module hcr_ctrl_reg
  import hcr_pkg::*;
#(
  parameter int DW       = HCR_DW,
  parameter int CLR_BIT  = HCR_WARM_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          hw_clr,
  output logic [DW-1:0] ctrl_q
);
  logic [DW-1:0] ctrl_d;
  logic          load_en;

  always_comb begin
    load_en = wr_stb | hw_clr;
    ctrl_d  = wr_stb ? wr_data : ctrl_q;
    if (hw_clr) ctrl_d[CLR_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (load_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/hcr_i2c_slave.sv
module hcr_i2c_slave
  import hcr_pkg::*;
#(
  parameter int                   SYNC_STAGES = 2,
  parameter logic [HCR_AW-1:0]    ADDR_BASE   = 7'h20,
  parameter logic [HCR_SEL_W-1:0] ADDR_ROT    = 3'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull_low,
  input  logic       card_answer,
  input  logic       card_mute,
  output logic       act_req,
  output logic       warm_req,
  output logic       vcc_3v_sel,
  output logic       card_clk_halt,
  output logic       card_clk_halt_high,
  output logic [1:0] card_clk_rate,
  output logic       aux_io_en
);
  logic              rst_meta_n;
  logic              rst_q_n;
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [HCR_AW-1:0] own_addr;
  logic [HCR_DW-1:0] ctrl_q;
  logic [HCR_DW-1:0] wr_data;
  logic              wr_stb;
  logic              hw_clr;
  logic              idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  hcr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  hcr_addr_map #(.BASE(ADDR_BASE), .ROT(ADDR_ROT)) u_map (
    .sel  (addr_sel),
    .addr (own_addr)
  );

  hcr_byte_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .own_addr  (own_addr),
    .reg_val   (ctrl_q),
    .sda_low   (sda_pull_low),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .idle      (idle)
  );

  assign hw_clr = card_answer | card_mute;

  hcr_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .hw_clr  (hw_clr),
    .ctrl_q  (ctrl_q)
  );

  assign act_req            = ctrl_q[0];
  assign warm_req           = ctrl_q[HCR_WARM_BIT];
  assign vcc_3v_sel         = ctrl_q[2];
  assign card_clk_halt      = ctrl_q[3];
  assign card_clk_halt_high = ctrl_q[4];
  assign card_clk_rate      = ctrl_q[6:5];
  assign aux_io_en          = ctrl_q[7];
endmodule

// File: rtl/hcr_i2c_slave_chk.sv
module hcr_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       card_answer,
  input logic       card_mute,
  input logic       sda_pull_low,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic [7:0] ctrl_q,
  input logic       stop_det,
  input logic       idle
);
  logic clr;
  assign clr = card_answer | card_mute;

  // R6
  warm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ctrl_q[1]);

  // R7
  clr_over_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && clr) |=> (ctrl_q == {$past(wr_data[7:2]), 1'b0, $past(wr_data[0])}));

  // R4
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !clr) |=> (ctrl_q == $past(wr_data)));

  // R4
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !clr) |=> $stable(ctrl_q));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_low);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull_low);
endmodule

bind hcr_i2c_slave hcr_i2c_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .card_answer  (card_answer),
  .card_mute    (card_mute),
  .sda_pull_low (sda_pull_low),
  .wr_stb       (wr_stb),
  .wr_data      (wr_data),
  .ctrl_q       (ctrl_q),
  .stop_det     (stop_det),
  .idle         (idle)
);

// File: tb/hcr_i2c_slave_test.sv
module hcr_i2c_slave_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr_sel;
  logic       scl;
  logic       m_low;
  logic       card_answer;
  logic       card_mute;
  logic       sda_line;
  logic       sda_pull_low;
  logic       act_req, warm_req, vcc_3v_sel, card_clk_halt, card_clk_halt_high, aux_io_en;
  logic [1:0] card_clk_rate;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  assign sda_line = !(m_low || sda_pull_low);

  hcr_i2c_slave uut (
    .clk                (clk),
    .rst_n              (rst_n),
    .addr_sel           (addr_sel),
    .scl_in             (scl),
    .sda_in             (sda_line),
    .sda_pull_low       (sda_pull_low),
    .card_answer        (card_answer),
    .card_mute          (card_mute),
    .act_req            (act_req),
    .warm_req           (warm_req),
    .vcc_3v_sel         (vcc_3v_sel),
    .card_clk_halt      (card_clk_halt),
    .card_clk_halt_high (card_clk_halt_high),
    .card_clk_rate      (card_clk_rate),
    .aux_io_en          (aux_io_en)
  );

  // R2 address table, written from the requirement
  function automatic logic [6:0] addr_of(input int s);
    case (s)
      0: return 7'h25;  1: return 7'h26;  2: return 7'h27;  3: return 7'h20;
      4: return 7'h21;  5: return 7'h22;  6: return 7'h23;  default: return 7'h24;
    endcase
  endfunction

  function automatic logic [7:0] ctrl_now();
    return {aux_io_en, card_clk_rate, card_clk_halt_high, card_clk_halt,
            vcc_3v_sel, warm_req, act_req};
  endfunction

  // scoreboard driver side: push expected item with the observation
  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tag_q.push_back(tag);
    exp_q.push_back(exp);
    got_q.push_back(got);
  endtask

  // scoreboard monitor side
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g;
        logic [7:0] e;
        string      t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (g !== e) begin
          n_fail++;
          $display("FAIL %s actual=%02h expected=%02h", t, g, e);
        end
      end
    end
  end

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wait_q(1);
    scl = 1'b1;   wait_q(1);
    m_low = 1'b1; wait_q(1);
    scl = 1'b0;   wait_q(1);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wait_q(1);
    scl = 1'b1;   wait_q(1);
    m_low = 1'b0; wait_q(2);
  endtask

  task automatic send_bit(input logic b);
    m_low = !b; wait_q(1);
    scl = 1'b1; wait_q(2);
    scl = 1'b0; wait_q(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; wait_q(1);
    scl = 1'b1;   wait_q(1);
    acked = !sda_line;
    wait_q(1);
    scl = 1'b0;   wait_q(1);
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      m_low = 1'b0; wait_q(1);
      scl = 1'b1;   wait_q(1);
      v = {v[6:0], sda_line};
      wait_q(1);
      scl = 1'b0;   wait_q(1);
    end
    m_low = master_ack; wait_q(1);
    scl = 1'b1;         wait_q(2);
    scl = 1'b0;         wait_q(1);
    m_low = 1'b0;
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] d,
                           output logic ack_a, output logic ack_d);
    bus_start();
    send_byte({a, 1'b0}, ack_a);
    send_byte(d, ack_d);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic       aa, ad, ax;
    logic [7:0] v1, v2;
    logic [6:0] own;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0;
    card_answer = 1'b0; card_mute = 1'b0; addr_sel = 3'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R1 reset register", ctrl_now(), 8'h00);
    check("R1 reset sda", {7'b0, sda_pull_low}, 8'h00);

    for (int k = 0; k < 3; k++) begin
      int         s;
      logic [7:0] val;
      s   = (k == 0) ? 0 : (k == 1) ? 3 : 7;
      val = (k == 0) ? 8'hA5 : (k == 1) ? 8'h5C : 8'h81;
      addr_sel = 3'(s);
      repeat (4) @(negedge clk);
      write_txn(addr_of(s), val, aa, ad);
      check($sformatf("R2 own address ack sel=%0d", s), {7'b0, aa}, 8'h01);
      check("R4 data byte ack", {7'b0, ad}, 8'h01);
      check("R4 register after write", ctrl_now(), val);
      write_txn(addr_of((s + 1) % 8), 8'h3C, aa, ad);
      check($sformatf("R2 foreign address no ack sel=%0d", s), {7'b0, aa}, 8'h00);
      check("R3 data after mismatch no ack", {7'b0, ad}, 8'h00);
      check("R3 register unchanged after mismatch", ctrl_now(), val);
    end

    own = addr_of(7);

    // R9 two data bytes in one write
    bus_start();
    send_byte({own, 1'b0}, aa);
    send_byte(8'h11, ad);
    check("R9 first byte ack", {7'b0, ad}, 8'h01);
    send_byte(8'h66, ad);
    check("R9 second byte ack", {7'b0, ad}, 8'h01);
    bus_stop();
    check("R9 register holds last byte", ctrl_now(), 8'h66);

    // R5 read with master ACK then NACK
    bus_start();
    send_byte({own, 1'b1}, aa);
    check("R5 read address ack", {7'b0, aa}, 8'h01);
    read_byte(1'b1, v1);
    read_byte(1'b0, v2);
    check("R5 first read byte", v1, 8'h66);
    check("R5 repeated read byte", v2, 8'h66);
    check("R5 sda released after nack", {7'b0, sda_pull_low}, 8'h00);
    bus_stop();

    // R8 repeated START into a read
    bus_start();
    send_byte({own, 1'b0}, aa);
    bus_start();
    send_byte({own, 1'b1}, aa);
    check("R8 ack after repeated start", {7'b0, aa}, 8'h01);
    read_byte(1'b0, v1);
    check("R8 read after repeated start", v1, 8'h66);
    bus_stop();

    // R8 repeated START after mismatch
    bus_start();
    send_byte({addr_of(0), 1'b0}, ax);
    check("R3 mismatch before restart", {7'b0, ax}, 8'h00);
    bus_start();
    send_byte({own, 1'b0}, aa);
    send_byte(8'h24, ad);
    bus_stop();
    check("R8 ack after restart from idle", {7'b0, aa}, 8'h01);
    check("R8 write after restart", ctrl_now(), 8'h24);

    // R6 hardware clears of bit1
    write_txn(own, 8'h0A, aa, ad);
    check("R6 warm bit set by write", ctrl_now(), 8'h0A);
    card_answer = 1'b1; @(negedge clk);
    card_answer = 1'b0; @(negedge clk);
    check("R6 card_answer clears bit1", ctrl_now(), 8'h08);
    write_txn(own, 8'h02, aa, ad);
    card_mute = 1'b1; @(negedge clk);
    card_mute = 1'b0; @(negedge clk);
    check("R6 card_mute clears bit1", ctrl_now(), 8'h00);

    // R7 clear held across the write strobe
    card_mute = 1'b1;
    write_txn(own, 8'hFF, aa, ad);
    card_mute = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 clear wins over write", ctrl_now(), 8'hFD);

    // R10 STOP in the middle of a data byte
    bus_start();
    send_byte({own, 1'b0}, aa);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    check("R10 partial byte ignored", ctrl_now(), 8'hFD);
    check("R10 sda released after stop", {7'b0, sda_pull_low}, 8'h00);

    repeat (4) @(negedge clk);
    while (got_q.size() > 0) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule